// File: doc/BRIEF.md
# Programmable Parallel Port Group

This block provides 24 general-purpose lines arranged as three byte-wide ports, named A, B and C, in plain input/output mode. A host reaches the ports and one control register through a byte-wide register interface. It has a 2-bit address and separate read and write strobes. The host sets the direction of each port with a mode-definition write to the control register. Port C is split into an upper and a lower nibble, and each nibble has its own direction.

Each port has an output latch. The latch drives the pads through separate out and output-enable signals. A read of a port returns the live pad level for lines set as input and the latch value for lines set as output. A read is captured on the clock edge where the read strobe is high and stays on `rd_data` until the next read.

Top module: `ppi_group`

## Requirements
- R1: Register address 0 selects port A (lines 7..0), address 1 selects port B (lines 15..8), address 2 selects port C (lines 23..16), and address 3 selects the control register.
- R2: After reset every line is an output (`pad_oe` all ones), every output latch holds zero (`pad_out` all zeros), and `rd_data` is zero.
- R3: A control write with bit 7 set reloads all directions. Bit 4 sets port A, bit 1 sets port B, bit 0 sets port C lines 3..0, and bit 3 sets port C lines 7..4. A one means input. `pad_oe` for each line is the inverse of its input bit, and the change is visible one cycle after the write.
- R4: A control write with bit 7 clear leaves every direction unchanged.
- R5: A port write loads that port's output latch. The latch appears on `pad_out` one cycle after the write, whatever the port's direction.
- R6: A port read returns, one cycle after the strobe, the `pad_in` level for input lines and the latch value for output lines.
- R7: `rd_data` holds its value in every cycle without a read strobe.
- R8: A latch keeps its contents while its port is an input, so the stored value is driven again when the port returns to output.
- R9: A control read returns bit 7 as one, bit 4 as the port A direction, bit 3 as the port C upper direction, bit 1 as the port B direction, bit 0 as the port C lower direction, and all other bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pad_in | input | 24 | Pad input levels |
| pad_out | output | 24 | Pad output values (latches) |
| pad_oe | output | 24 | Pad output enables, high for output |

## Verification
The block answers every access exactly one cycle later. A write changes `pad_out` and `pad_oe` on the clock edge that samples the strobe, so the bench checks pads at the next falling edge. A read captures `rd_data` on the sampling edge. The driver queues the expected byte when it issues the read, and the monitor pops it and compares at the falling edge after the edge where it saw `rd_en`. Hold and no-effect cases are checked at the ports several cycles after the stimulus, before any further access.

// File: rtl/ppi_group.sv
module ppi_group #(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      addr,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [PW-1:0]   rd_data,
  input  logic [3*PW-1:0] pad_in,
  output logic [3*PW-1:0] pad_out,
  output logic [3*PW-1:0] pad_oe
);
  localparam int NL = 3 * PW;
  localparam int HW = PW / 2;

  logic [PW-1:0] lat_a, lat_b, lat_c;
  logic          in_a, in_b, in_cl, in_ch;
  logic [NL-1:0] in_mask;
  logic [NL-1:0] view;
  logic [PW-1:0] ctrl_view;
  logic [PW-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
      in_a  <= 1'b0;
      in_b  <= 1'b0;
      in_cl <= 1'b0;
      in_ch <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        2'd0: lat_a <= wr_data;
        2'd1: lat_b <= wr_data;
        2'd2: lat_c <= wr_data;
        default: if (wr_data[7]) begin
          in_a  <= wr_data[4];
          in_b  <= wr_data[1];
          in_cl <= wr_data[0];
          in_ch <= wr_data[3];
        end
      endcase
    end
  end

  assign in_mask = {{HW{in_ch}}, {HW{in_cl}}, {PW{in_b}}, {PW{in_a}}};
  assign pad_out = {lat_c, lat_b, lat_a};
  assign pad_oe  = ~in_mask;
  assign view    = (pad_in & in_mask) | (pad_out & ~in_mask);

  always_comb begin
    ctrl_view    = '0;
    ctrl_view[7] = 1'b1;
    ctrl_view[4] = in_a;
    ctrl_view[3] = in_ch;
    ctrl_view[1] = in_b;
    ctrl_view[0] = in_cl;
  end

  always_comb begin
    case (addr)
      2'd0:    rd_next = view[PW-1:0];
      2'd1:    rd_next = view[2*PW-1:PW];
      2'd2:    rd_next = view[NL-1:2*PW];
      default: rd_next = ctrl_view;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  AST_OE_A_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[PW-1:0] == '0) || (pad_oe[PW-1:0] == '1)); // R3
  AST_CTRL_NOMODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !wr_data[7]) |=> $stable(pad_oe)); // R4
  AST_LATCH_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (pad_out[PW-1:0] == $past(wr_data))); // R5
  AST_PADS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pad_out) && $stable(pad_oe))); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R7
endmodule

// File: tb/sim_ppi_group.sv
module sim_ppi_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [23:0] pad_in = '0;
  logic [23:0] pad_out;
  logic [23:0] pad_oe;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ppi_group u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R6 unexpected read actual=%h expected=none", rd_data);
        end else begin
          check(tag_q.pop_front(), {16'h0, rd_data}, {16'h0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 oe", pad_oe, 24'hFFFFFF);
    check("R2 out", pad_out, 24'h000000);
    check("R2 rd", {16'h0, rd_data}, 24'h0);
    rd(2'd0, 8'h00, "R2 latch A read");

    wr(2'd0, 8'h5A);
    check("R5 R1 port A out", pad_out, 24'h00005A);
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hA5);
    check("R1 R5 all ports out", pad_out, 24'hA53C5A);
    rd(2'd0, 8'h5A, "R6 R1 read A");
    rd(2'd1, 8'h3C, "R6 R1 read B");
    rd(2'd2, 8'hA5, "R6 R1 read C");
    rd(2'd3, 8'h80, "R9 ctrl reset");

    pad_in = 24'h123456;
    wr(2'd3, 8'h90);
    check("R3 A input oe", pad_oe, 24'hFFFF00);
    rd(2'd0, 8'h56, "R6 A input pads");
    rd(2'd1, 8'h3C, "R6 B output latch");

    wr(2'd3, 8'h0B);
    check("R4 no mode oe", pad_oe, 24'hFFFF00);
    rd(2'd3, 8'h90, "R4 R9 ctrl unchanged");

    wr(2'd3, 8'h89);
    check("R3 C both in oe", pad_oe, 24'h00FFFF);
    rd(2'd2, 8'h12, "R6 C input");
    rd(2'd3, 8'h89, "R9 ctrl C");

    wr(2'd3, 8'h81);
    check("R3 C low in oe", pad_oe, 24'hF0FFFF);
    rd(2'd2, 8'hA2, "R6 C mixed nibbles");

    wr(2'd3, 8'h82);
    check("R3 B in oe", pad_oe, 24'hFF00FF);
    rd(2'd1, 8'h34, "R6 B input");
    wr(2'd1, 8'h77);
    check("R5 B latch while input", pad_out, 24'hA5775A);
    rd(2'd1, 8'h34, "R6 B still pads");
    wr(2'd3, 8'h80);
    check("R3 all out oe", pad_oe, 24'hFFFFFF);
    rd(2'd1, 8'h77, "R8 B latch restored");
    rd(2'd0, 8'h5A, "R8 A latch restored");

    wr(2'd3, 8'h90);
    rd(2'd0, 8'h56, "R6 A input again");
    pad_in = 24'h0000FF;
    repeat (3) @(negedge clk);
    check("R7 rd hold", {16'h0, rd_data}, 24'h000056);

    repeat (2) @(negedge clk);
    check("R6 queue drained", 24'(exp_q.size()), 24'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule